// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash device. Once a program or erase command has been issued elsewhere, a pulse on `start` hands the poller a status address. The poller then reads status bytes over a simple read port and watches the toggle bit (data bit 6). While an embedded operation runs, bit 6 flips on every read. When it holds steady, the operation is over. Data bit 5 is the device's "time limit exceeded" flag. When it is set while bit 6 still toggles, the poller takes one more fresh pair of reads. This covers the case where toggling stopped just as the flag rose.

When the poller decides the operation failed, it writes a reset command over a write port. The command is one parameterised address and data pair. The poller then reports a failure. A poll-count limit keeps a device that toggles forever from hanging the poller. An `abort` input drops the machine back to idle at any time. Every accepted `start` begins again with a new pair of reads.

Top module: `tbit_poller`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `done`, `pass`, `fail`, `rd_req` and `wr_req` are all low.
- R2: After a start, the first two completed reads are compared on bit 6. If they are equal, the poller ends with `done` and `pass` high and issues no further read. It holds that result until the next start or abort.
- R3: If bit 6 differs and bit 5 of the latest byte is 1, the poller takes a new pair of reads. If the two bytes of that pair are equal on bit 6, it ends with `pass`.
- R4: If bit 6 differs and bit 5 is 0, the next read is compared with the latest byte. This continues until bit 6 is equal, which ends with `pass`.
- R5: If the recheck pair from R3 still differs on bit 6, the outcome is failure.
- R6: On failure, `wr_req` rises with `wr_addr` = RST_ADDR and `wr_data` = RST_DATA. `fail` is high and `done` is low until `wr_ack` is seen. After that, `done` and `fail` are high and `pass` is low.
- R7: With MAX_POLLS nonzero, the MAX_POLLS-th consecutive R4-style evaluation (bit 6 differs, bit 5 clear) forces the failure path of R6. A value of 0 disables the limit.
- R8: `abort` returns the poller to idle on the next cycle, with all outputs low. A later start begins with a fresh first read.
- R9: `rd_addr` equals the `start_addr` sampled with the accepted start, and it is held for the whole poll.
- R10: A `start` while reads or the reset write are in progress is ignored. The poll address and the outcome are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (accepted when idle or done) |
| abort | input | 1 | Return to idle |
| start_addr | input | AW | Status address to poll |
| rd_req | output | 1 | Read request, held until `rd_valid` |
| rd_addr | output | AW | Read address |
| rd_data | input | 8 | Returned status byte |
| rd_valid | input | 1 | `rd_data` valid, completes the read |
| wr_req | output | 1 | Reset-command write request |
| wr_addr | output | AW | Reset-command address |
| wr_data | output | 8 | Reset-command data |
| wr_ack | input | 1 | Write accepted |
| done | output | 1 | Poll finished |
| pass | output | 1 | Finished with success |
| fail | output | 1 | Failure decided / finished with failure |

## Verification
A corrupted stored bit 6 or a lost recheck flag would show up at the ports within one read. The result would be the wrong verdict or the wrong read count: an extra or missing `rd_valid` is consumed before `done` rises. A counter that is off by one moves the forced failure by exactly one read in the constant-toggle case. The bench therefore checks the number of reads consumed, and the number and content of the writes, against a behavioural model of the decision sequence. Every clock it also checks that `fail` is held through the reset write and that the poll address never moves.

// File: rtl/tbit_pkg.sv
package tbit_pkg;

    localparam int TOGGLE_POS = 6;
    localparam int LIMIT_POS  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_RESET,
        ST_DONE
    } poll_state_e;

    typedef enum logic [1:0] {
        V_PASS,
        V_FAIL,
        V_RECHECK,
        V_CONTINUE
    } verdict_e;

    typedef struct packed {
        logic ref_bit;
        logic recheck;
        logic failed;
    } poll_ctx_t;

    function automatic verdict_e judge(input logic [7:0] cur,
                                       input logic       ref_bit,
                                       input logic       recheck,
                                       input logic       limit_last);
        if (cur[TOGGLE_POS] == ref_bit) return V_PASS;
        if (recheck)                    return V_FAIL;
        if (cur[LIMIT_POS])             return V_RECHECK;
        if (limit_last)                 return V_FAIL;
        return V_CONTINUE;
    endfunction

endpackage

// File: rtl/tbit_poll_limit.sv
module tbit_poll_limit #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam bit          LIMITED = (MAX_POLLS != 0);
    localparam int          CW      = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam int unsigned TOP     = LIMITED ? MAX_POLLS - 1 : 0;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (step)
            cnt <= cnt + 1'b1;
    end

    assign last = LIMITED && (cnt == CW'(TOP));

endmodule

// File: rtl/tbit_poll_fsm.sv
module tbit_poll_fsm
    import tbit_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          abort,
    input  logic [AW-1:0] start_addr,
    input  logic [7:0]    rd_data,
    input  logic          rd_valid,
    input  logic          wr_ack,
    input  logic          limit_last,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic          wr_req,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic          cnt_clr,
    output logic          cnt_step
);
    poll_state_e   state;
    poll_ctx_t     ctx;
    logic [AW-1:0] addr_q;
    verdict_e      verdict;
    logic          launch;

    assign launch  = start && !abort && (state == ST_IDLE || state == ST_DONE);
    assign verdict = judge(rd_data, ctx.ref_bit, ctx.recheck, limit_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ctx    <= '0;
            addr_q <= '0;
        end else if (abort) begin
            state      <= ST_IDLE;
            ctx.failed <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (launch) begin
                        state       <= ST_FIRST;
                        addr_q      <= start_addr;
                        ctx.recheck <= 1'b0;
                        ctx.failed  <= 1'b0;
                    end
                end
                ST_FIRST: begin
                    if (rd_valid) begin
                        ctx.ref_bit <= rd_data[TOGGLE_POS];
                        state       <= ST_SECOND;
                    end
                end
                ST_SECOND: begin
                    if (rd_valid) begin
                        case (verdict)
                            V_PASS:    state <= ST_DONE;
                            V_FAIL: begin
                                state      <= ST_RESET;
                                ctx.failed <= 1'b1;
                            end
                            V_RECHECK: begin
                                ctx.recheck <= 1'b1;
                                state       <= ST_FIRST;
                            end
                            default:   ctx.ref_bit <= rd_data[TOGGLE_POS];
                        endcase
                    end
                end
                ST_RESET: begin
                    if (wr_ack) state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rd_req   = (state == ST_FIRST) || (state == ST_SECOND);
    assign rd_addr  = addr_q;
    assign wr_req   = (state == ST_RESET);
    assign done     = (state == ST_DONE);
    assign pass     = done && !ctx.failed;
    assign fail     = ctx.failed && (done || wr_req);
    assign cnt_clr  = launch;
    assign cnt_step = (state == ST_SECOND) && rd_valid && (verdict == V_CONTINUE);

endmodule

// File: rtl/tbit_poller.sv
module tbit_poller #(
    parameter int          AW        = 20,
    parameter int          MAX_POLLS = 1024,
    parameter logic [AW-1:0] RST_ADDR = 'h555,
    parameter logic [7:0]  RST_DATA  = 8'hF0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          abort,
    input  logic [AW-1:0] start_addr,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    input  logic          rd_valid,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    input  logic          wr_ack,
    output logic          done,
    output logic          pass,
    output logic          fail
);
    logic cnt_clr, cnt_step, limit_last;

    tbit_poll_limit #(.MAX_POLLS(MAX_POLLS)) limit_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_clr),
        .step (cnt_step),
        .last (limit_last)
    );

    tbit_poll_fsm #(.AW(AW)) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .abort      (abort),
        .start_addr (start_addr),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .wr_ack     (wr_ack),
        .limit_last (limit_last),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .wr_req     (wr_req),
        .done       (done),
        .pass       (pass),
        .fail       (fail),
        .cnt_clr    (cnt_clr),
        .cnt_step   (cnt_step)
    );

    assign wr_addr = RST_ADDR;
    assign wr_data = RST_DATA;

endmodule

// File: rtl/tbit_poller_chk.sv
module tbit_poller_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          abort,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          wr_req,
    input logic          wr_ack,
    input logic          done,
    input logic          pass,
    input logic          fail
);
    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail)); // R6
    AST_FAIL_DURING_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> (fail && !done)); // R6
    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack && !abort) |=> wr_req); // R6
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (!rd_req && !wr_req)); // R2
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!rd_req && !wr_req && !done && !pass && !fail)); // R8
    AST_LAUNCH_READS: assert property (@(posedge clk) disable iff (rst)
        (start && !abort && !rd_req && !wr_req) |=> rd_req); // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (rd_req && $past(rd_req)) |-> $stable(rd_addr)); // R9
    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (start && rd_req) |=> $stable(rd_addr)); // R10
endmodule

bind tbit_poller tbit_poller_chk #(.AW(AW)) chk_i (.*);

// File: tb/tbit_poller_tb.sv
module tbit_poller_tb_top;
    localparam int          AW    = 16;
    localparam int          MAXP  = 4;
    localparam logic [15:0] RADDR = 16'h0AAA;
    localparam logic [7:0]  RDATA = 8'hF0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          abort = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data = 8'h00;
    logic          rd_valid = 1'b0;
    logic          wr_req;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          wr_ack = 1'b0;
    logic          done, pass, fail;

    tbit_poller #(.AW(AW), .MAX_POLLS(MAXP), .RST_ADDR(RADDR), .RST_DATA(RDATA)) dut_i (
        .clk(clk), .rst(rst), .start(start), .abort(abort), .start_addr(start_addr),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .done(done), .pass(pass), .fail(fail)
    );

    always #10 clk = ~clk;

    int            errors = 0;
    int            checks = 0;
    logic [7:0]    rq[$];
    int            reads = 0;
    int            writes = 0;
    int            rd_lat = 0;
    logic [AW-1:0] last_wa = '0;
    logic [7:0]    last_wd = '0;
    logic [AW-1:0] exp_addr = '0;
    bit            mon_en = 1'b0;
    int            cycles = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_all();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Read responder: one byte per accepted read, after rd_lat idle cycles
    initial begin
        int lat_cnt = 0;
        forever begin
            @(negedge clk);
            if (rd_valid) begin
                rd_valid = 1'b0;
                lat_cnt  = 0;
            end else if (rd_req) begin
                if (lat_cnt >= rd_lat) begin
                    rd_data  = (rq.size() > 0) ? rq.pop_front() : 8'h00;
                    rd_valid = 1'b1;
                    reads++;
                    lat_cnt  = 0;
                end else begin
                    lat_cnt++;
                end
            end else begin
                lat_cnt = 0;
            end
        end
    end

    // Write responder: acknowledges after three cycles
    initial begin
        int wl = 0;
        forever begin
            @(negedge clk);
            if (wr_ack) begin
                wr_ack = 1'b0;
                wl     = 0;
            end else if (wr_req) begin
                if (wl >= 3) begin
                    wr_ack  = 1'b1;
                    last_wa = wr_addr;
                    last_wd = wr_data;
                    writes++;
                    wl      = 0;
                end else begin
                    wl++;
                end
            end else begin
                wl = 0;
            end
        end
    end

    // Per-clock comparison of the outputs against the rules
    always @(negedge clk) begin
        if (mon_en) begin
            check(!(pass && fail), "R6", "pass and fail together", int'(pass), 0);
            if (wr_req)
                check(fail && !done, "R6", "fail held during reset write",
                      int'({fail, done}), 2);
            if (rd_req)
                check(rd_addr == exp_addr, "R9", "poll address", int'(rd_addr),
                      int'(exp_addr));
            if (done)
                check(!rd_req && !wr_req, "R2", "bus idle when done",
                      int'({rd_req, wr_req}), 0);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            finish_all();
        end
    end

    // Behavioural model of the decision sequence over a list of status bytes
    function automatic void model(input logic [7:0] d[$], input int maxp,
                                  output int nreads, output bit ok);
        logic prev;
        bit   rech = 1'b0;
        int   cnt = 0;
        int   i = 1;
        prev = d[0][6];
        ok = 1'b0;
        forever begin
            logic [7:0] cur;
            cur = d[i];
            i++;
            if (cur[6] == prev) begin
                ok = 1'b1;
                break;
            end else if (rech) begin
                break;
            end else if (cur[5]) begin
                rech = 1'b1;
                prev = d[i][6];
                i++;
            end else begin
                cnt++;
                if (maxp != 0 && cnt == maxp) break;
                prev = cur[6];
            end
        end
        nreads = i;
    endfunction

    task automatic pulse_start(input logic [AW-1:0] a);
        @(negedge clk);
        start_addr = a;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_case(input string req, input logic [7:0] seq[$],
                            input logic [AW-1:0] a, input int lat);
        int exp_reads;
        bit exp_ok;
        int r0, w0;
        model(seq, MAXP, exp_reads, exp_ok);
        rq       = seq;
        rd_lat   = lat;
        r0       = reads;
        w0       = writes;
        exp_addr = a;
        pulse_start(a);
        wait_done();
        check(done == 1'b1, req, "done", int'(done), 1);
        check(pass == exp_ok, req, "pass", int'(pass), int'(exp_ok));
        check(fail == !exp_ok, req, "fail", int'(fail), int'(!exp_ok));
        check(reads - r0 == exp_reads, req, "reads consumed", reads - r0, exp_reads);
        check(writes - w0 == (exp_ok ? 0 : 1), "R6", "reset writes", writes - w0,
              exp_ok ? 0 : 1);
        if (!exp_ok) begin
            check(last_wa == RADDR, "R6", "reset address", int'(last_wa), int'(RADDR));
            check(last_wd == RDATA, "R6", "reset data", int'(last_wd), int'(RDATA));
        end
        repeat (5) @(negedge clk);
        check(reads - r0 == exp_reads, "R2", "no read after done", reads - r0, exp_reads);
        check(done && (pass == exp_ok), "R2", "result held", int'({done, pass}),
              int'({1'b1, exp_ok}));
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check({done, pass, fail, rd_req, wr_req} == 5'b0, "R1", "outputs in reset",
              int'({done, pass, fail, rd_req, wr_req}), 0);
        rst = 1'b0;
        @(negedge clk);
        check({done, pass, fail, rd_req, wr_req} == 5'b0, "R1", "outputs after reset",
              int'({done, pass, fail, rd_req, wr_req}), 0);
        mon_en = 1'b1;

        run_case("R2", '{8'h44, 8'h44}, 16'h0100, 0);
        run_case("R2", '{8'h00, 8'h9B}, 16'h0104, 2);
        run_case("R4", '{8'h00, 8'h40, 8'h40}, 16'h0200, 1);
        run_case("R3", '{8'h00, 8'h60, 8'h20, 8'h20}, 16'h0300, 0);
        run_case("R5", '{8'h00, 8'h60, 8'h20, 8'h60}, 16'h0400, 2);
        run_case("R7", '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00}, 16'h0500, 0);
        run_case("R7", '{8'h00, 8'h40, 8'h00, 8'h40, 8'h40}, 16'h0504, 0);

        // R10: start while reads are in progress is ignored
        begin
            int r0;
            rq       = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h40};
            rd_lat   = 1;
            r0       = reads;
            exp_addr = 16'h0600;
            pulse_start(16'h0600);
            while (reads - r0 < 2) @(negedge clk);
            pulse_start(16'h1234);
            wait_done();
            check(pass && done, "R10", "outcome unchanged by busy start",
                  int'({done, pass}), 3);
            check(reads - r0 == 5, "R10", "reads with busy start", reads - r0, 5);
        end

        // R8: abort mid-poll, then a fresh start
        begin
            int r0;
            rq       = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00};
            rd_lat   = 0;
            r0       = reads;
            exp_addr = 16'h0700;
            pulse_start(16'h0700);
            while (reads - r0 < 2) @(negedge clk);
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
            check({done, pass, fail, rd_req, wr_req} == 5'b0, "R8", "idle after abort",
                  int'({done, pass, fail, rd_req, wr_req}), 0);
            repeat (3) @(negedge clk);
            check(rd_req == 1'b0, "R8", "no reads while idle", int'(rd_req), 0);
        end
        run_case("R8", '{8'h40, 8'h40}, 16'h0710, 0);

        // R8: abort during the reset write
        begin
            rq       = '{8'h00, 8'h60, 8'h20, 8'h60};
            rd_lat   = 0;
            exp_addr = 16'h0800;
            pulse_start(16'h0800);
            while (!wr_req) @(negedge clk);
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
            check({done, fail, wr_req} == 3'b0, "R8", "abort clears reset write",
                  int'({done, fail, wr_req}), 0);
            repeat (4) @(negedge clk);
        end
        run_case("R3", '{8'h20, 8'h60, 8'h00, 8'h00}, 16'h0900, 1);

        finish_all();
    end
endmodule